// File: doc/BRIEF.md
# Bit-Serial Binary Crossbar Multiply-Accumulate

This block is a digital model of a processing element built on a matrix of single-bit cells. Each cell is either on or off, so one cell holds one bit of a weight. Each output group owns a set of adjacent columns, one column per weight bit. A window of unsigned features is loaded in one cycle. The block then drives the matrix one row per cycle, one feature bit-plane at a time, starting with the least significant plane. In every such cycle, each column whose cell in the driven row is on adds the row's feature bit to its own pulse counter.

When a bit-plane has covered all of its rows, each group folds its column counts into a signed value. Each column count is weighted by the significance of its weight bit, and the top weight bit is counted negatively. The group then shifts that value by the plane index and adds it into its accumulator. The result is one signed dot product per group, formed without any multiplier. The array is programmed one row at a time through a write port, and row writes are locked out while a window is being computed.

Top module: `xbar_mac`

## Requirements
- R1: A cycle with `wr_en` high and `wr_row` below ROWS stores `wr_bits` as that row. Bit g*WBITS+k of the row is bit k of the weight of group g. A write naming a row at or above ROWS changes nothing.
- R2: Each group's result equals the sum over the used rows r of feature r times the group's weight in row r. Feature r is the unsigned field `vec_data[r*FBITS +: FBITS]`. The weight is two's complement, so its top bit has the value -2^(WBITS-1).
- R3: A window is accepted only on a clock edge where `start` and `vec_valid` are both high and the block is idle. `vec_data` and `n_rows` are captured at that edge, and later changes to them have no effect on the window. A `start` without `vec_valid` is ignored.
- R4: If a window using n rows is accepted at edge 0, `done` rises at edge FBITS*n+1 and stays high for exactly one cycle.
- R5: An `n_rows` of 0 or above ROWS is treated as ROWS. Rows at or above the effective count contribute nothing to any result.
- R6: After reset `done` is low and every result is zero. The results hold their value from the edge that raises `done` until the next accepted window.
- R7: A row write sampled after the accepting edge, up to and including the edge that raises `done`, is ignored. The array keeps its previous contents for later windows.
- R8: A `start` that arrives while a window is in progress is ignored. The running window completes with its original timing and result.
- R9: A row write and an accepted `start` in the same cycle are both carried out, and the window uses the newly written row.
- R10: Results are exact with no wrap-around at the extremes: every weight at its most negative or most positive value, every feature at its maximum, and all ROWS rows in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write request |
| wr_row | input | RW | Row index for the write |
| wr_bits | input | GROUPS*WBITS | Cell values for the row being written |
| start | input | 1 | Begin a window |
| vec_valid | input | 1 | Qualifies `vec_data` and `n_rows` together with `start` |
| vec_data | input | ROWS*FBITS | Flattened feature window, element r in bits r*FBITS upward |
| n_rows | input | $clog2(ROWS+1) | Number of rows in use |
| done | output | 1 | One-cycle pulse when the results are complete |
| result | output | GROUPS*ACCW | Signed dot products, group g in bits g*ACCW upward |

## Verification
The two functions that can meet in one cycle are a row write and the start of a window. A write that lands a few cycles into a running window must be ignored, and this is judged by checking that both that window and the next one still match the old weights. A write that lands in the same idle cycle as an accepted start must take effect first, and the result is compared against the new weights. A second start injected during a run is judged by the unchanged `done` latency and the unchanged result. Both results are checked against dot products computed in the bench, including an exhaustive single-row sweep over every weight and feature value.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {
    XB_IDLE = 1'b0,
    XB_RUN  = 1'b1
  } xb_state_e;

  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_cells.sv
module xbar_cells #(
  parameter int ROWS = 36,
  parameter int COLS = 64,
  parameter int RW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [COLS-1:0] wr_bits,
  input  logic            lock,
  input  logic [RW-1:0]   rd_row,
  output logic [COLS-1:0] rd_bits
);

  logic [ROWS-1:0][COLS-1:0] cells_q;
  logic                      wr_ok;

  assign wr_ok   = wr_en && !lock && (int'(wr_row) < ROWS);
  assign rd_bits = cells_q[rd_row];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    assign row_we = wr_ok && (int'(wr_row) == r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells_q[r] <= '0;
      end else if (row_we) begin
        cells_q[r] <= wr_bits;
      end
    end
  end

  // array contents frozen while a window is running
  p_cells_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cells_q));

endmodule

// File: rtl/xbar_seq.sv
module xbar_seq
  import xbar_pkg::*;
#(
  parameter int ROWS  = 36,
  parameter int FBITS = 8,
  parameter int RW    = 6,
  parameter int NW    = 6,
  parameter int PW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  vec_valid,
  input  logic [ROWS*FBITS-1:0] vec_data,
  input  logic [NW-1:0]         n_rows,
  output logic                  busy,
  output logic                  accept,
  output logic [RW-1:0]         rd_row,
  output logic                  drive_en,
  output logic                  drive_bit,
  output logic                  plane_first,
  output logic                  acc_en,
  output logic [PW-1:0]         acc_plane,
  output logic                  done
);

  xb_state_e                 state_q, state_d;
  logic [RW-1:0]             row_q, row_d;
  logic [PW-1:0]             plane_q, plane_d;
  logic [NW-1:0]             nrow_q, nrow_d;
  logic [ROWS-1:0][FBITS-1:0] vec_q, vec_d;
  logic                      end_q, end_d;
  logic [PW-1:0]             endp_q, endp_d;
  logic                      done_q, done_d;
  logic                      last_row, last_plane;
  logic [NW-1:0]             n_eff;

  always_comb begin
    busy       = (state_q == XB_RUN) || end_q;
    accept     = start && vec_valid && !busy;
    last_row   = (NW'(row_q) + NW'(1)) == nrow_q;
    last_plane = plane_q == PW'(FBITS - 1);
    n_eff      = ((n_rows == '0) || (int'(n_rows) > ROWS)) ? NW'(ROWS) : n_rows;

    state_d = state_q;
    row_d   = row_q;
    plane_d = plane_q;
    nrow_d  = nrow_q;
    vec_d   = vec_q;
    end_d   = 1'b0;
    endp_d  = endp_q;
    done_d  = end_q && (endp_q == PW'(FBITS - 1));

    if (accept) begin
      state_d = XB_RUN;
      row_d   = '0;
      plane_d = '0;
      nrow_d  = n_eff;
      vec_d   = vec_data;
    end else if (state_q == XB_RUN) begin
      end_d  = last_row;
      endp_d = plane_q;
      if (last_row) begin
        row_d = '0;
        if (last_plane) begin
          state_d = XB_IDLE;
        end else begin
          plane_d = plane_q + PW'(1);
        end
      end else begin
        row_d = row_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XB_IDLE;
      row_q   <= '0;
      plane_q <= '0;
      nrow_q  <= '0;
      vec_q   <= '0;
      end_q   <= 1'b0;
      endp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      plane_q <= plane_d;
      nrow_q  <= nrow_d;
      vec_q   <= vec_d;
      end_q   <= end_d;
      endp_q  <= endp_d;
      done_q  <= done_d;
    end
  end

  assign rd_row      = row_q;
  assign drive_en    = state_q == XB_RUN;
  assign drive_bit   = (state_q == XB_RUN) && vec_q[row_q][plane_q];
  assign plane_first = (state_q == XB_RUN) && (row_q == '0);
  assign acc_en      = end_q;
  assign acc_plane   = endp_q;
  assign done        = done_q;

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // the row being driven is always inside the accepted row count
  p_row_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XB_RUN) |-> (NW'(row_q) < nrow_q));

  // a start while running leaves the row walk undisturbed
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == XB_RUN) && !last_row && start) |=> (row_q == $past(row_q) + RW'(1)));

endmodule

// File: rtl/xbar_colcnt.sv
module xbar_colcnt #(
  parameter int ROWS = 36,
  parameter int COLS = 64,
  parameter int CW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_en,
  input  logic             drive_bit,
  input  logic             plane_first,
  input  logic [COLS-1:0]  row_bits,
  output logic [COLS*CW-1:0] cnt
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pulse;

    always_comb begin
      pulse = drive_bit && row_bits[c];
      cnt_d = (plane_first ? CW'(0) : cnt_q) + CW'(pulse);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (drive_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign cnt[c*CW +: CW] = cnt_q;

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= ROWS);
  end

endmodule

// File: rtl/xbar_combine.sv
module xbar_combine #(
  parameter int GROUPS = 8,
  parameter int WBITS  = 8,
  parameter int CW     = 6,
  parameter int PW     = 3,
  parameter int ACCW   = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       acc_en,
  input  logic [PW-1:0]              plane,
  input  logic [GROUPS*WBITS*CW-1:0] cnt,
  output logic [GROUPS*ACCW-1:0]     acc
);

  localparam int GW = CW + WBITS + 1;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic signed [GW-1:0]   grp_val;
    logic signed [ACCW-1:0] grp_ext, grp_sh;
    logic signed [ACCW-1:0] acc_q, acc_d;

    always_comb begin
      grp_val = '0;
      for (int k = 0; k < WBITS; k++) begin
        logic signed [GW-1:0] term;
        term = $signed({{(GW-CW){1'b0}}, cnt[(g*WBITS+k)*CW +: CW]}) <<< k;
        if (k == WBITS - 1) begin
          grp_val = grp_val - term;
        end else begin
          grp_val = grp_val + term;
        end
      end
      grp_ext = {{(ACCW-GW){grp_val[GW-1]}}, grp_val};
      grp_sh  = grp_ext <<< plane;
      acc_d   = clr ? '0 : (acc_q + grp_sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (clr || acc_en) begin
        acc_q <= acc_d;
      end
    end

    assign acc[g*ACCW +: ACCW] = acc_q;
  end

endmodule

// File: rtl/xbar_mac.sv
module xbar_mac #(
  parameter int ROWS   = 36,
  parameter int GROUPS = 8,
  parameter int WBITS  = 8,
  parameter int FBITS  = 8,
  localparam int COLS  = GROUPS * WBITS,
  localparam int RW    = xbar_pkg::idx_w(ROWS),
  localparam int NW    = $clog2(ROWS + 1),
  localparam int PW    = xbar_pkg::idx_w(FBITS),
  localparam int CW    = $clog2(ROWS + 1),
  localparam int ACCW  = CW + WBITS + FBITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RW-1:0]          wr_row,
  input  logic [COLS-1:0]        wr_bits,
  input  logic                   start,
  input  logic                   vec_valid,
  input  logic [ROWS*FBITS-1:0]  vec_data,
  input  logic [NW-1:0]          n_rows,
  output logic                   done,
  output logic [GROUPS*ACCW-1:0] result
);

  logic            busy_w, accept_w;
  logic [RW-1:0]   rd_row_w;
  logic [COLS-1:0] rd_bits_w;
  logic            drive_en_w, drive_bit_w, plane_first_w;
  logic            acc_en_w;
  logic [PW-1:0]   acc_plane_w;
  logic [COLS*CW-1:0] cnt_w;

  xbar_seq #(
    .ROWS(ROWS), .FBITS(FBITS), .RW(RW), .NW(NW), .PW(PW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .vec_valid(vec_valid), .vec_data(vec_data), .n_rows(n_rows),
    .busy(busy_w), .accept(accept_w), .rd_row(rd_row_w),
    .drive_en(drive_en_w), .drive_bit(drive_bit_w), .plane_first(plane_first_w),
    .acc_en(acc_en_w), .acc_plane(acc_plane_w), .done(done)
  );

  xbar_cells #(
    .ROWS(ROWS), .COLS(COLS), .RW(RW)
  ) u_cells (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_row(wr_row), .wr_bits(wr_bits),
    .lock(busy_w), .rd_row(rd_row_w), .rd_bits(rd_bits_w)
  );

  xbar_colcnt #(
    .ROWS(ROWS), .COLS(COLS), .CW(CW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .drive_en(drive_en_w), .drive_bit(drive_bit_w), .plane_first(plane_first_w),
    .row_bits(rd_bits_w), .cnt(cnt_w)
  );

  xbar_combine #(
    .GROUPS(GROUPS), .WBITS(WBITS), .CW(CW), .PW(PW), .ACCW(ACCW)
  ) u_comb (
    .clk(clk), .rst_n(rst_n),
    .clr(accept_w), .acc_en(acc_en_w), .plane(acc_plane_w),
    .cnt(cnt_w), .acc(result)
  );

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !accept_w) |=> $stable(result));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_w);

endmodule

// File: tb/xbar_mac_tb.sv
module xbar_mac_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 6;
  localparam int GROUPS = 2;
  localparam int WBITS  = 8;
  localparam int FBITS  = 4;
  localparam int COLS   = GROUPS * WBITS;
  localparam int RW     = $clog2(ROWS);
  localparam int NW     = $clog2(ROWS + 1);
  localparam int CW     = $clog2(ROWS + 1);
  localparam int ACCW   = CW + WBITS + FBITS;

  logic                   clk;
  logic                   rst_n;
  logic                   wr_en;
  logic [RW-1:0]          wr_row;
  logic [COLS-1:0]        wr_bits;
  logic                   start;
  logic                   vec_valid;
  logic [ROWS*FBITS-1:0]  vec_data;
  logic [NW-1:0]          n_rows;
  logic                   done;
  logic [GROUPS*ACCW-1:0] result;

  int n_chk;
  int n_bad;

  logic signed [WBITS-1:0] wm [ROWS][GROUPS];
  logic        [FBITS-1:0] fv [ROWS];

  xbar_mac #(.ROWS(ROWS), .GROUPS(GROUPS), .WBITS(WBITS), .FBITS(FBITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_bits(wr_bits),
    .start(start), .vec_valid(vec_valid), .vec_data(vec_data), .n_rows(n_rows),
    .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [COLS-1:0] pack_row(input int r);
    logic [COLS-1:0] b;
    for (int g = 0; g < GROUPS; g++) b[g*WBITS +: WBITS] = wm[r][g];
    return b;
  endfunction

  function automatic logic [ROWS*FBITS-1:0] pack_vec();
    logic [ROWS*FBITS-1:0] v;
    for (int r = 0; r < ROWS; r++) v[r*FBITS +: FBITS] = fv[r];
    return v;
  endfunction

  function automatic int eff_rows(input int n);
    return (n == 0 || n > ROWS) ? ROWS : n;
  endfunction

  function automatic longint expect_g(input int g, input int n);
    longint s = 0;
    for (int r = 0; r < eff_rows(n); r++) s += longint'(fv[r]) * longint'(wm[r][g]);
    return s;
  endfunction

  function automatic longint got(input int g);
    logic signed [ACCW-1:0] s;
    s = result[g*ACCW +: ACCW];
    return longint'(s);
  endfunction

  task automatic raw_write(input int r, input logic [COLS-1:0] bits);
    @(negedge clk);
    wr_en = 1'b1; wr_row = RW'(r); wr_bits = bits;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_row(input int r);
    raw_write(r, pack_row(r));
  endtask

  // mode 0 plain, 1 write during run, 2 second start during run, 3 write together with start
  task automatic run(input string req, input int n, input int mode);
    int lat = 0;
    bit seen = 0;
    int t = FBITS * eff_rows(n);
    @(negedge clk);
    start = 1'b1; vec_valid = 1'b1; vec_data = pack_vec(); n_rows = NW'(n);
    if (mode == 3) begin
      wr_en = 1'b1; wr_row = RW'(1); wr_bits = pack_row(1);
    end
    while (!seen && lat < t + 20) begin
      @(negedge clk);
      lat++;
      start = 1'b0; vec_valid = 1'b0; wr_en = 1'b0;
      if (lat == 1) begin
        vec_data = ~pack_vec(); n_rows = NW'(1);
      end
      if (lat == 3 && mode == 1) begin
        wr_en = 1'b1; wr_row = RW'(0); wr_bits = ~pack_row(0);
      end
      if (lat == 3 && mode == 2) begin
        start = 1'b1; vec_valid = 1'b1;
      end
      if (done) seen = 1;
    end
    check("R4", "done latency", longint'(lat), longint'(t + 2));
    for (int g = 0; g < GROUPS; g++) check(req, "group result", got(g), expect_g(g, n));
    @(negedge clk);
    check("R4", "done width", longint'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_bits = '0;
    start = 1'b0; vec_valid = 1'b0; vec_data = '0; n_rows = '0;
    repeat (3) @(negedge clk);
    check("R6", "reset done", longint'(done), 0);
    for (int g = 0; g < GROUPS; g++) check("R6", "reset result", got(g), 0);
    rst_n = 1'b1;

    // R1: program every row, then run full windows
    for (int r = 0; r < ROWS; r++) begin
      for (int g = 0; g < GROUPS; g++) wm[r][g] = WBITS'($urandom);
      load_row(r);
    end
    for (int i = 0; i < 4; i++) begin
      for (int r = 0; r < ROWS; r++) fv[r] = FBITS'($urandom);
      run("R1", ROWS, 0);
    end

    // R5: every row count, including 0 and one above ROWS
    for (int n = 0; n <= ROWS + 1; n++) begin
      for (int r = 0; r < ROWS; r++) fv[r] = FBITS'($urandom);
      run("R5", n, 0);
    end

    // R2: single-plane features check LSB-first significance
    for (int p = 0; p < FBITS; p++) begin
      for (int r = 0; r < ROWS; r++) fv[r] = FBITS'(1 << p);
      run("R2", ROWS, 0);
    end

    // R2: random weights and features
    for (int i = 0; i < 30; i++) begin
      if (i % 5 == 0) begin
        for (int r = 0; r < ROWS; r++) begin
          for (int g = 0; g < GROUPS; g++) wm[r][g] = WBITS'($urandom);
          load_row(r);
        end
      end
      for (int r = 0; r < ROWS; r++) fv[r] = FBITS'($urandom);
      run("R2", 1 + (i % ROWS), 0);
    end

    // R2: exhaustive single-row sweep over weight and feature values
    for (int r = 1; r < ROWS; r++) fv[r] = '1;
    for (int w = 0; w < (1 << WBITS); w++) begin
      wm[0][0] = WBITS'(w);
      wm[0][1] = ~WBITS'(w);
      load_row(0);
      for (int f = 0; f < (1 << FBITS); f++) begin
        fv[0] = FBITS'(f);
        run("R2", 1, 0);
      end
    end

    // R10: extremes over all rows
    for (int r = 0; r < ROWS; r++) begin
      wm[r][0] = {1'b1, {(WBITS-1){1'b0}}};
      wm[r][1] = {1'b0, {(WBITS-1){1'b1}}};
      fv[r] = '1;
      load_row(r);
    end
    run("R10", ROWS, 0);
    for (int r = 0; r < ROWS; r++) begin
      wm[r][0] = {1'b0, {(WBITS-1){1'b1}}};
      wm[r][1] = {1'b1, {(WBITS-1){1'b0}}};
      load_row(r);
    end
    run("R10", ROWS, 0);

    // R7: write during a run is dropped, now and for the next window
    for (int r = 0; r < ROWS; r++) fv[r] = FBITS'($urandom);
    run("R7", ROWS, 1);
    run("R7", ROWS, 0);

    // R8: second start during a run
    for (int r = 0; r < ROWS; r++) fv[r] = FBITS'($urandom);
    run("R8", ROWS, 2);

    // R9: write coincident with an accepted start
    for (int g = 0; g < GROUPS; g++) wm[1][g] = WBITS'($urandom);
    for (int r = 0; r < ROWS; r++) fv[r] = '1;
    run("R9", ROWS, 3);

    // R1: out-of-range row write ignored
    raw_write(ROWS, '1);
    run("R1", ROWS, 0);

    // R3 and R6: start without valid does nothing, results hold
    @(negedge clk);
    start = 1'b1; vec_valid = 1'b0; vec_data = '0;
    begin
      int pulses = 0;
      for (int c = 0; c < 4 * FBITS * ROWS; c++) begin
        @(negedge clk);
        start = 1'b0;
        if (done) pulses++;
      end
      check("R3", "done without valid", longint'(pulses), 0);
    end
    for (int g = 0; g < GROUPS; g++) check("R6", "held result", got(g), expect_g(g, ROWS));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule